// File: doc/BRIEF.md
# Double-Precision Round-and-Pack Unit

This block is the last stage of a double-precision arithmetic datapath. An upstream adder, multiplier or divider hands it a sign, a signed unbiased exponent and a 56-bit significand. That significand holds the hidden bit at bit 55, 52 fraction bits, and three extra low bits: guard, round and sticky. The block returns the finished 64-bit IEEE 754 double together with the inexact, underflow and overflow flags.

Several steps happen inside the block:
- Values below the normal range are denormalised with a sticky right shift.
- The significand is rounded in one of four modes, and the exponent is bumped if the rounding carries out.
- Results beyond the finite range saturate to infinity or to the largest finite value, depending on the rounding mode and the sign.
- When flush mode is on, tiny inputs are replaced at once by a fixed result chosen by rounding mode and sign.

The block has one register stage: a result appears one clock after its input is marked valid. An exact zero is never presented as input.

Top module: `dp_round_pack`

## Requirements
- R1: `out_valid` is high exactly one clock after a cycle in which `in_valid` was high, and low one clock after a cycle in which it was low. Reset (active-low `rst_n`) clears `out_valid`, the result and all three flags.
- R2: Round-to-nearest-even (`rnd_mode` = 0) behaves as follows. Low bits above half (5 to 7) round up. Exactly half (low bits = 4) rounds up only when significand bit 3 is 1. Below half truncates.
- R3: Toward-zero (`rnd_mode` = 1) truncates. Upward (`rnd_mode` = 2) adds one unit in bit 3 only for positive values. Downward (`rnd_mode` = 3) adds it only for negative values. A mode that adds no unit simply drops the three low bits.
- R4: Inexact is raised whenever the significand reaching the rounder has any of its three low bits set. An in-range input (exponent -1022 to +1023) with zero low bits gives no inexact and no overflow.
- R5: If rounding carries past the hidden bit, the significand is shifted right by one and the exponent is incremented.
- R6: An exponent below -1022 (with flush off) is raised to -1022, and the significand is shifted right by the same amount. Every bit shifted out is ORed into bit 0, and shifts of 56 or more leave only that sticky bit. Underflow is raised when the shifted value is inexact and its hidden bit is clear.
- R7: At exponent -1023, the significand is rounded first. If that carries out, the result is normal with exponent -1022: inexact is set and underflow is not.
- R8: A result whose hidden bit is clear is packed with exponent field 0. It raises underflow when it was inexact, and it also raises underflow whenever `uf_trap_en` is 1.
- R9: With `flush_en` = 1 and exponent below -1022, the block raises underflow and inexact. The result is ±smallest normal (0x0010000000000000 magnitude) when rounding away from zero in a directed mode, meaning upward for positive or downward for negative. In every other case the result is a zero with the input's sign.
- R10: A final exponent above +1023 raises overflow and inexact. The result is ±infinity for nearest, for upward with positive values and for downward with negative values. All other cases give the largest finite value (0x7FEFFFFFFFFFFFFF magnitude) with the input's sign.
- R11: A normal result is packed as the sign in bit 63, exponent+1023 in bits 62:52, and the 52 fraction bits below the hidden bit. The sign bit always equals the input sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operands valid this cycle |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EXP_W (13) | Signed unbiased exponent |
| in_sig | input | 56 | Hidden bit, 52 fraction bits, guard/round/sticky |
| rnd_mode | input | 2 | 0 nearest-even, 1 toward zero, 2 upward, 3 downward |
| flush_en | input | 1 | Replace tiny values by the flush table |
| uf_trap_en | input | 1 | Raise underflow on exact tiny results too |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Packed double result |
| out_inexact | output | 1 | Inexact flag |
| out_underflow | output | 1 | Underflow flag |
| out_overflow | output | 1 | Overflow flag |

## Verification
The bound checker watches several properties on every cycle:
- the one-cycle valid latency;
- that the sign passes through unchanged;
- that exact in-range inputs stay clean of inexact and overflow;
- that overflow always comes with inexact and a saturated magnitude;
- that flushed inputs yield underflow, inexact and one of the two flush magnitudes.

Other behaviours can only be shown by the bench's directed and random vectors, checked against its behavioural model:
- which saturated value each mode and sign pair selects;
- the tie-to-even decision;
- the sticky shift contents;
- the exponent -1023 rounding escape;
- the trap-enable effect on exact tiny results.

// File: rtl/dp_round_pack.sv
module dp_round_pack #(
  parameter int EXP_W = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [55:0]             in_sig,
  input  logic [1:0]              rnd_mode,
  input  logic                    flush_en,
  input  logic                    uf_trap_en,
  output logic                    out_valid,
  output logic [63:0]             out_result,
  output logic                    out_inexact,
  output logic                    out_underflow,
  output logic                    out_overflow
);
  localparam int SIG_W = 56;
  localparam int EMIN  = -1022;
  localparam int EMAX  = 1023;
  localparam int BIAS  = 1023;
  localparam logic [62:0] MAG_INF  = 63'h7FF0_0000_0000_0000;
  localparam logic [62:0] MAG_MAXF = 63'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [62:0] MAG_MINN = 63'h0010_0000_0000_0000;

  function automatic logic [SIG_W:0] round_add(input logic s, input logic [SIG_W:0] m,
                                               input logic [1:0] mode);
    if (m[2:0] == 3'd0) return m;
    case (mode)
      2'd0:    return m + 57'd3 + {56'd0, m[3]};
      2'd1:    return m;
      2'd2:    return s ? m : m + 57'd8;
      default: return s ? m + 57'd8 : m;
    endcase
  endfunction

  function automatic logic [SIG_W-1:0] sticky_shift(input logic [SIG_W-1:0] m,
                                                    input int unsigned sh);
    logic lost;
    if (sh >= SIG_W) return {{(SIG_W-1){1'b0}}, |m};
    lost = |(m & ~({SIG_W{1'b1}} << sh));
    return (m >> sh) | {{(SIG_W-1){1'b0}}, lost};
  endfunction

  logic away;
  assign away = (rnd_mode == 2'd2 && !in_sign) || (rnd_mode == 2'd3 && in_sign);

  int             e_w;
  logic [SIG_W:0] m_w, r_w;
  logic           nx_w, uf_w, ov_w;
  logic [63:0]    res_w;

  always_comb begin
    e_w   = int'(in_exp);
    m_w   = {1'b0, in_sig};
    r_w   = round_add(in_sign, m_w, rnd_mode);
    nx_w  = 1'b0;
    uf_w  = 1'b0;
    ov_w  = 1'b0;
    res_w = '0;
    if (e_w < EMIN && flush_en) begin
      nx_w  = 1'b1;
      uf_w  = 1'b1;
      res_w = {in_sign, away ? MAG_MINN : 63'd0};
    end else begin
      if (e_w < EMIN) begin
        if (e_w == EMIN - 1 && r_w[SIG_W]) begin
          m_w  = {1'b0, r_w[SIG_W:1]} & ~57'd7;
          nx_w = 1'b1;
        end else begin
          m_w = {1'b0, sticky_shift(in_sig, EMIN - e_w)};
        end
        e_w = EMIN;
      end
      if (m_w[2:0] != 3'd0) begin
        nx_w = 1'b1;
        if (!m_w[SIG_W-1]) uf_w = 1'b1;
        m_w = round_add(in_sign, m_w, rnd_mode);
        if (m_w[SIG_W]) begin
          m_w = m_w >> 1;
          e_w = e_w + 1;
        end
      end
      if (e_w > EMAX) begin
        ov_w  = 1'b1;
        nx_w  = 1'b1;
        res_w = {in_sign, (rnd_mode == 2'd0 || away) ? MAG_INF : MAG_MAXF};
      end else if (!m_w[SIG_W-1]) begin
        res_w = {in_sign, 11'd0, m_w[54:3]};
        if (uf_trap_en) uf_w = 1'b1;
      end else begin
        res_w = {in_sign, 11'(e_w + BIAS), m_w[54:3]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_result    <= '0;
      out_inexact   <= 1'b0;
      out_underflow <= 1'b0;
      out_overflow  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result    <= res_w;
        out_inexact   <= nx_w;
        out_underflow <= uf_w;
        out_overflow  <= ov_w;
      end
    end
  end
endmodule

// File: rtl/dp_round_pack_chk.sv
module dp_round_pack_chk #(
  parameter int EXP_W = 13
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_sign,
  input logic signed [EXP_W-1:0] in_exp,
  input logic [55:0]             in_sig,
  input logic                    flush_en,
  input logic                    out_valid,
  input logic [63:0]             out_result,
  input logic                    out_inexact,
  input logic                    out_underflow,
  input logic                    out_overflow
);
  localparam logic [62:0] C_INF  = 63'h7FF0_0000_0000_0000;
  localparam logic [62:0] C_MAXF = 63'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [62:0] C_MINN = 63'h0010_0000_0000_0000;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_result[63] == $past(in_sign)); // R11
  AST_EXACT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sig[2:0] == 3'd0 && in_exp >= -1022 && in_exp <= 1023)
    |=> (!out_inexact && !out_overflow)); // R4
  AST_OVF_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow)
    |-> (out_inexact && (out_result[62:0] == C_INF || out_result[62:0] == C_MAXF))); // R10
  AST_FLUSH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && flush_en && in_exp < -1022)
    |=> (out_underflow && out_inexact && !out_overflow
         && (out_result[62:0] == 63'd0 || out_result[62:0] == C_MINN))); // R9
endmodule

bind dp_round_pack dp_round_pack_chk #(.EXP_W(EXP_W)) u_chk (.*);

// File: tb/dp_round_pack_test.sv
`timescale 1ns/1ps
module dp_round_pack_test;
  localparam logic [63:0] INF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] MAXF = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINN = 64'h0010_0000_0000_0000;
  localparam longint unsigned ONE   = 64'h0080_0000_0000_0000;
  localparam longint unsigned ALL1  = 64'h00FF_FFFF_FFFF_FFFF;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0, in_sign = 1'b0, flush_en = 1'b0, uf_trap_en = 1'b0;
  logic signed [12:0] in_exp = '0;
  logic [55:0]        in_sig = '0;
  logic [1:0]         rnd_mode = '0;
  logic               out_valid, out_inexact, out_underflow, out_overflow;
  logic [63:0]        out_result;

  dp_round_pack uut (.*);

  logic [66:0] expq[$];
  string       tagq[$];
  int n_vec = 0, n_bad = 0;

  function automatic longint unsigned rounded(bit s, longint unsigned m, int rm);
    bit up;
    if ((m & 7) == 0) return m;
    case (rm)
      0: up = ((m & 7) > 4) || ((m & 7) == 4 && (m & 8) != 0);
      1: up = 0;
      2: up = !s;
      default: up = s;
    endcase
    return up ? (m & ~64'd7) + 8 : (m & ~64'd7);
  endfunction

  function automatic logic [66:0] model(bit s, int e, longint unsigned m, int rm,
                                        bit ftz, bit trap);
    bit nx = 0, uf = 0, away;
    longint unsigned q;
    logic [10:0] ef;
    away = (rm == 2 && !s) || (rm == 3 && s);
    if (e < -1022 && ftz) return {3'b110, away ? {s, MINN[62:0]} : {s, 63'd0}};
    if (e < -1022) begin
      q = rounded(s, m, rm);
      if (e == -1023 && q >= (64'd1 << 56)) begin
        m = (q >> 1) & ~64'd7; e = -1022; nx = 1;
      end else begin
        while (e < -1022) begin m = (m >> 1) | (m & 1); e++; end
      end
    end
    if ((m & 7) != 0) begin
      nx = 1;
      if (m < (64'd1 << 55)) uf = 1;
      m = rounded(s, m, rm);
      if (m >= (64'd1 << 56)) begin m = m >> 1; e++; end
    end
    m = m >> 3;
    if (e > 1023) return {1'b1, uf, 1'b1, (rm == 0 || away) ? {s, INF[62:0]} : {s, MAXF[62:0]}};
    if (m < (64'd1 << 52)) return {nx, uf | trap, 1'b0, s, 11'd0, m[51:0]};
    ef = 11'(e + 1023);
    return {nx, uf, 1'b0, s, ef, m[51:0]};
  endfunction

  task automatic compare();
    logic [66:0] exp_v;
    string tag;
    n_vec++;
    if (expq.size() > 0) begin
      exp_v = expq.pop_front();
      tag = tagq.pop_front();
      if (!out_valid || {out_inexact, out_underflow, out_overflow, out_result} !== exp_v) begin
        n_bad++;
        $display("FAIL %s: actual v=%b nx/uf/ov=%b%b%b res=%h expected v=1 nx/uf/ov=%b res=%h",
                 tag, out_valid, out_inexact, out_underflow, out_overflow, out_result,
                 exp_v[66:64], exp_v[63:0]);
      end
    end else if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 idle: actual out_valid=%b expected 0", out_valid);
    end
  endtask

  task automatic step(bit v, bit s, int e, longint unsigned m, int rm, bit ftz, bit trap,
                      string tag);
    @(negedge clk);
    compare();
    in_valid = v; in_sign = s; in_exp = 13'(e); in_sig = m[55:0];
    rnd_mode = 2'(rm); flush_en = ftz; uf_trap_en = trap;
    if (v) begin
      expq.push_back(model(s, e, m, rm, ftz, trap));
      tagq.push_back(tag);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || out_result !== 64'd0 || {out_inexact, out_underflow, out_overflow} !== 3'b000) begin
      n_bad++;
      $display("FAIL R1 reset: actual v=%b res=%h flags=%b%b%b expected all zero",
               out_valid, out_result, out_inexact, out_underflow, out_overflow);
    end
    rst_n = 1'b1;

    step(1, 1, 0, ONE, 0, 0, 0, "R11 minus one");
    step(1, 0, 10, ONE | 64'h123450, 1, 0, 0, "R11 exact normal");
    step(0, 0, 0, 0, 0, 0, 0, "R1 idle");
    step(1, 0, 3, ONE | 64'h8, 0, 0, 0, "R4 exact no inexact");
    step(1, 0, 0, ONE | 4, 0, 0, 0, "R2 tie even stays");
    step(1, 0, 0, ONE | 64'hC, 0, 0, 0, "R2 tie odd rounds up");
    step(1, 1, 0, ONE | 5, 0, 0, 0, "R2 above half");
    step(1, 0, 0, ONE | 3, 0, 0, 0, "R2 below half");
    for (int rm = 0; rm < 4; rm++)
      for (int s = 0; s < 2; s++)
        step(1, s[0], -7, ONE | 64'h9, rm, 0, 0, "R3 mode and sign");
    step(1, 0, 5, ALL1, 0, 0, 0, "R5 carry out");
    step(1, 1, 5, ALL1, 3, 0, 0, "R5 carry out downward");
    step(1, 0, -1030, ONE | 1, 0, 0, 0, "R6 denormal sticky");
    step(1, 1, -1075, ONE | 64'h300, 2, 0, 0, "R6 deep shift");
    step(1, 0, -1100, ALL1, 2, 0, 0, "R6 saturating shift");
    step(1, 0, -2000, ONE, 1, 0, 0, "R6 saturating shift zero");
    step(1, 0, -1023, ALL1, 0, 0, 0, "R7 escapes to min normal");
    step(1, 0, -1023, ALL1, 1, 0, 0, "R7 toward zero stays tiny");
    step(1, 1, -1023, ALL1, 3, 0, 0, "R7 downward negative");
    step(1, 0, -1023, ONE, 0, 0, 0, "R8 exact tiny no trap");
    step(1, 1, -1023, ONE, 0, 0, 1, "R8 exact tiny trap");
    step(1, 0, -1022, ONE, 0, 0, 1, "R8 normal ignores trap");
    for (int rm = 0; rm < 4; rm++)
      for (int s = 0; s < 2; s++)
        step(1, s[0], -1023, ONE | 64'h10, rm, 1, 0, "R9 flush table");
    for (int rm = 0; rm < 4; rm++)
      for (int s = 0; s < 2; s++)
        step(1, s[0], 1024, ONE, rm, 0, 0, "R10 overflow table");
    step(1, 0, 1023, ALL1, 0, 0, 0, "R10 overflow by carry");
    step(1, 1, 1023, ALL1, 1, 0, 0, "R10 max finite no carry");

    for (int i = 0; i < 4000; i++) begin
      longint unsigned m;
      int e, sel;
      m = {$urandom, $urandom};
      m = (m & ALL1) | ONE;
      sel = $urandom_range(0, 5);
      case (sel)
        0: e = $urandom_range(0, 2400) - 1200;
        1: e = $urandom_range(0, 60) - 1080;
        2: e = $urandom_range(0, 4) - 1024;
        3: e = $urandom_range(0, 4) + 1021;
        4: begin e = $urandom_range(0, 8) - 1024; m = m | 64'h7; end
        default: e = $urandom_range(0, 200) - 100;
      endcase
      step($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, e, m,
           $urandom_range(0, 3), $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
           "R11 random");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R1 drain");
    @(negedge clk);
    compare();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule